// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This block is the per-processor half of an interrupt controller that deals with taking and retiring interrupts. It accepts an acknowledge request and an end-of-interrupt (EOI) request, and it tracks which interrupt the processor is running now and at what priority. Arbitration among pending sources happens elsewhere. This unit receives only the current best pending ID, the source priority table and the per-source configuration bits. It answers with the acknowledged ID and emits one-cycle commands that tell the pending-state store to clear or re-set a bit.

Nested preemption is held as a linked chain. Every source that is active keeps a link entry that names the interrupt it preempted. The value 1023 is reserved to mean "none". An EOI for the running interrupt returns to the linked predecessor. An EOI for an interrupt deeper in the chain removes it from the middle of the chain. To do that, the unit walks the chain one link per clock, and during the walk both request channels are held off.

Both request channels follow a valid/ready protocol. A request is taken on a rising edge where valid and ready are both high. The requester must hold valid and its data stable until that edge. Ready is low while a chain walk is in progress. When both channels are valid in the same cycle, the acknowledge request wins and the EOI request waits. Acknowledge results are single-cycle pulses with no back-pressure, and they appear one clock after the request is taken.

Top module: `irq_ack_eoi_unit`

## Requirements
- R1: An acknowledge is rejected and changes no state when the pending ID is 1023, when it names no implemented source, or when its priority is not strictly lower in number than the running priority. A rejected acknowledge returns ack_id = 1023 with ack_rsp_valid high and pclr_valid low.
- R2: An accepted acknowledge stores the previously running ID as the link entry of the acknowledged source. It then makes the acknowledged ID the running ID.
- R3: An accepted acknowledge pulses pclr_valid together with ack_rsp_valid, with pclr_id equal to the acknowledged ID. pclr_all is 1 (clear for every processor) when the source's src_onen bit is 1, and 0 (clear for this processor only) otherwise.
- R4: run_prio is the priority of the running source zero-extended to 9 bits. It is 0x100 whenever run_id is 1023, including after reset.
- R5: An EOI taken while run_id is 1023 has no effect: the running state stays the same and no pset_valid pulse is produced.
- R6: An EOI for a source whose src_edge bit is 0 (level type) and whose src_en, src_level and src_tgt bits are all 1 pulses pset_valid with pset_id set to that source one clock later. A source with src_edge = 1 never produces this pulse.
- R7: An EOI whose ID equals run_id sets run_id to that source's stored link entry and sets run_prio to match.
- R8: An EOI for an ID that is not running walks the chain from run_id. When it reaches the entry that links to that ID, it replaces that entry with the completed ID's own link. run_id does not change.
- R9: An EOI for an ID that does not appear in the chain ends its walk at a link of 1023 and leaves the running state unchanged.
- R10: While a chain walk is in progress, ack_ready and eoi_ready are both low. The walk takes one clock per link visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_valid | input | 1 | Acknowledge request valid |
| ack_ready | output | 1 | Acknowledge request can be taken |
| hp_id | input | 10 | Current highest-pending ID (1023 = none) |
| ack_rsp_valid | output | 1 | One-cycle pulse: acknowledge result on ack_id |
| ack_id | output | 10 | Acknowledged ID, or 1023 when rejected |
| eoi_valid | input | 1 | EOI request valid |
| eoi_ready | output | 1 | EOI request can be taken |
| eoi_id | input | 10 | ID being completed |
| prio_flat | input | NUM_SRC*8 | Priority of source i at bits [8i+7:8i]; a lower value is more urgent |
| src_edge | input | NUM_SRC | 1 = edge type, 0 = level type |
| src_onen | input | NUM_SRC | 1 = one-of-N model (clear pending for all processors) |
| src_level | input | NUM_SRC | Current input level of each source |
| src_en | input | NUM_SRC | Source enabled for this processor |
| src_tgt | input | NUM_SRC | Source targets this processor |
| pclr_valid | output | 1 | One-cycle pending-clear command |
| pclr_id | output | 10 | Source to clear |
| pclr_all | output | 1 | Clear for all processors (1) or this one only (0) |
| pset_valid | output | 1 | One-cycle pending-set command |
| pset_id | output | 10 | Source to set pending again |
| run_id | output | 10 | Running interrupt ID (1023 = none) |
| run_prio | output | 9 | Running priority (0x100 = none) |

## Verification
The hardest situation to reach from the ports is an EOI for an interrupt buried in the middle of a chain at least three deep. The stimulus has to build the nesting first, through acknowledges with strictly falling priority values. Only a later run of EOIs shows the effect, when returning from the top interrupt lands on the grandparent instead of the removed one. The vector table sets up a three-deep nest and removes the middle entry. A directed test then removes the bottom entry, which forces a two-link walk, and samples both ready signals during that walk.

// File: rtl/acu_pkg.sv
package acu_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;
  localparam logic [PRIO_W:0] PRIO_IDLE = 9'h100;

  typedef enum logic {ST_IDLE, ST_WALK} acu_state_e;
endpackage

// File: rtl/acu_prio_mux.sv
module acu_prio_mux
  import acu_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic [ID_W-1:0]           id,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [PRIO_W:0]           prio
);
  // Unknown or absent IDs map to the idle value, which never wins a compare.
  always_comb begin
    prio = PRIO_IDLE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (id == ID_W'(i)) prio = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]};
    end
  end
endmodule

// File: rtl/acu_link_mem.sv
module acu_link_mem
  import acu_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [ID_W-1:0] waddr,
  input  logic [ID_W-1:0] wdata,
  input  logic [ID_W-1:0] raddr_a,
  output logic [ID_W-1:0] rdata_a,
  input  logic [ID_W-1:0] raddr_b,
  output logic [ID_W-1:0] rdata_b
);
  logic [ID_W-1:0] ent [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent[g] <= ID_NONE;
      else if (we && waddr == ID_W'(g)) ent[g] <= wdata;
    end
  end

  always_comb begin
    rdata_a = ID_NONE;
    rdata_b = ID_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (raddr_a == ID_W'(i)) rdata_a = ent[i];
      if (raddr_b == ID_W'(i)) rdata_b = ent[i];
    end
  end

  // R2: only implemented sources ever receive a link entry
  p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr < ID_W'(NUM_SRC)));
endmodule

// File: rtl/irq_ack_eoi_unit.sv
module irq_ack_eoi_unit
  import acu_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_valid,
  output logic                      ack_ready,
  input  logic [ID_W-1:0]           hp_id,
  output logic                      ack_rsp_valid,
  output logic [ID_W-1:0]           ack_id,
  input  logic                      eoi_valid,
  output logic                      eoi_ready,
  input  logic [ID_W-1:0]           eoi_id,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [NUM_SRC-1:0]        src_edge,
  input  logic [NUM_SRC-1:0]        src_onen,
  input  logic [NUM_SRC-1:0]        src_level,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        src_tgt,
  output logic                      pclr_valid,
  output logic [ID_W-1:0]           pclr_id,
  output logic                      pclr_all,
  output logic                      pset_valid,
  output logic [ID_W-1:0]           pset_id,
  output logic [ID_W-1:0]           run_id,
  output logic [PRIO_W:0]           run_prio
);
  acu_state_e      state;
  logic [ID_W-1:0] cur, walk_tgt;
  logic [ID_W-1:0] lnk_a, lnk_b, raddr_a, raddr_b, waddr, wdata;
  logic [PRIO_W:0] hp_prio, lnk_prio;
  logic            ack_fire, eoi_fire, ack_ok, rearm, onen_hp, walk_hit, walk_end, we;

  assign ack_ready = (state == ST_IDLE);
  assign eoi_ready = (state == ST_IDLE) && !ack_valid;
  assign ack_fire  = ack_valid && ack_ready;
  assign eoi_fire  = eoi_valid && eoi_ready;

  assign raddr_a = (state == ST_WALK) ? cur : run_id;
  assign raddr_b = walk_tgt;

  acu_link_mem #(.NUM_SRC(NUM_SRC)) u_link (
    .clk, .rst_n, .we, .waddr, .wdata,
    .raddr_a, .rdata_a(lnk_a), .raddr_b, .rdata_b(lnk_b)
  );

  acu_prio_mux #(.NUM_SRC(NUM_SRC)) u_hp_prio  (.id(hp_id), .prio_flat, .prio(hp_prio));
  acu_prio_mux #(.NUM_SRC(NUM_SRC)) u_lnk_prio (.id(lnk_a), .prio_flat, .prio(lnk_prio));

  // Per-source lookups for the acknowledge and EOI targets.
  always_comb begin
    onen_hp = 1'b0;
    rearm   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hp_id == ID_W'(i)) onen_hp = src_onen[i];
      if (eoi_id == ID_W'(i))
        rearm = !src_edge[i] && src_en[i] && src_level[i] && src_tgt[i];
    end
  end

  assign ack_ok   = hp_prio < run_prio;
  assign walk_end = (lnk_a == ID_NONE);
  assign walk_hit = !walk_end && (lnk_a == walk_tgt);
  assign we       = (ack_fire && ack_ok) || (state == ST_WALK && walk_hit);
  assign waddr    = (state == ST_WALK) ? cur   : hp_id;
  assign wdata    = (state == ST_WALK) ? lnk_b : run_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      run_id        <= ID_NONE;
      run_prio      <= PRIO_IDLE;
      ack_rsp_valid <= 1'b0;
      ack_id        <= ID_NONE;
      pclr_valid    <= 1'b0;
      pclr_id       <= ID_NONE;
      pclr_all      <= 1'b0;
      pset_valid    <= 1'b0;
      pset_id       <= ID_NONE;
      cur           <= ID_NONE;
      walk_tgt      <= ID_NONE;
    end else begin
      ack_rsp_valid <= 1'b0;
      pclr_valid    <= 1'b0;
      pset_valid    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ack_fire) begin
            ack_rsp_valid <= 1'b1;
            if (ack_ok) begin
              ack_id     <= hp_id;
              run_id     <= hp_id;
              run_prio   <= hp_prio;
              pclr_valid <= 1'b1;
              pclr_id    <= hp_id;
              pclr_all   <= onen_hp;
            end else begin
              ack_id <= ID_NONE;
            end
          end else if (eoi_fire && run_id != ID_NONE) begin
            if (rearm) begin
              pset_valid <= 1'b1;
              pset_id    <= eoi_id;
            end
            if (eoi_id == run_id) begin
              run_id   <= lnk_a;
              run_prio <= lnk_prio;
            end else begin
              state    <= ST_WALK;
              cur      <= run_id;
              walk_tgt <= eoi_id;
            end
          end
        end
        ST_WALK: begin
          if (walk_end || walk_hit) state <= ST_IDLE;
          else cur <= lnk_a;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a rejected acknowledge leaves the running state alone
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !(hp_prio < run_prio)) |=> (ack_id == ID_NONE && $stable(run_id) && !pclr_valid));
  // R3: a clear command only travels with an acknowledge result of the same ID
  p_pclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pclr_valid |-> (ack_rsp_valid && pclr_id == ack_id));
  // R4: no running interrupt means the idle priority
  p_runprio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == ID_NONE) |-> (run_prio == PRIO_IDLE));
  // R5: an EOI with nothing running has no effect
  p_eoi_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && run_id == ID_NONE) |=> ($stable(run_id) && !pset_valid && state == ST_IDLE));
  // R8: the walk never alters the running interrupt
  p_walk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WALK) |=> $stable(run_id));
endmodule

// File: tb/irq_ack_eoi_unit_bench.sv
module irq_ack_eoi_unit_bench;
  localparam int N = 16;
  localparam logic [9:0] NONE = 10'd1023;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ack_valid = 1'b0, eoi_valid = 1'b0;
  logic [9:0] hp_id = NONE, eoi_id = NONE;
  logic [N*8-1:0] prio_flat;
  logic [N-1:0] src_edge = '0, src_onen = 16'h0002, src_level = '0, src_en = '0, src_tgt = '0;
  logic ack_ready, eoi_ready, ack_rsp_valid, pclr_valid, pclr_all, pset_valid;
  logic [9:0] ack_id, pclr_id, pset_id, run_id;
  logic [8:0] run_prio;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic cap_rsp, cap_pclr, cap_pall, cap_pset, cap_busy;
  logic [9:0] cap_ack, cap_pclr_id, cap_pset_id;

  always #2 clk = ~clk;

  // priority of source i is i*16
  always_comb for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = 8'(i*16);

  irq_ack_eoi_unit #(.NUM_SRC(N)) u_irq_ack_eoi_unit (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_ack(input logic [9:0] hp);
    @(negedge clk);
    while (!ack_ready) @(negedge clk);
    hp_id = hp; ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    cap_rsp = ack_rsp_valid; cap_ack = ack_id;
    cap_pclr = pclr_valid; cap_pclr_id = pclr_id; cap_pall = pclr_all;
  endtask

  task automatic do_eoi(input logic [9:0] id);
    @(negedge clk);
    while (!eoi_ready) @(negedge clk);
    eoi_id = id; eoi_valid = 1'b1;
    @(negedge clk);
    eoi_valid = 1'b0;
    cap_pset = pset_valid; cap_pset_id = pset_id;
    cap_busy = !ack_ready && !eoi_ready;
    while (!eoi_ready) @(negedge clk);
  endtask

  // op(1) id(10) exp_ack(10) exp_run(10) exp_prio(9); op 0 = acknowledge, 1 = EOI
  localparam int NV = 13;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 10'd5,    10'd5,    10'd5,    9'h050},  // R2 first nest level
    {1'b0, 10'd7,    NONE,     10'd5,    9'h050},  // R1 lower urgency
    {1'b0, 10'd5,    NONE,     10'd5,    9'h050},  // R1 equal priority
    {1'b1, 10'd7,    NONE,     10'd5,    9'h050},  // R9 not in chain
    {1'b0, 10'd3,    10'd3,    10'd3,    9'h030},  // R2
    {1'b0, 10'd1,    10'd1,    10'd1,    9'h010},  // R2
    {1'b1, 10'd3,    NONE,     10'd1,    9'h010},  // R8 unlink middle
    {1'b1, 10'd1,    NONE,     10'd5,    9'h050},  // R7 skips removed entry
    {1'b1, 10'd5,    NONE,     NONE,     9'h100},  // R4 back to idle
    {1'b1, 10'd2,    NONE,     NONE,     9'h100},  // R5 nothing running
    {1'b0, NONE,     NONE,     NONE,     9'h100},  // R1 no pending
    {1'b0, 10'd2,    10'd2,    10'd2,    9'h020},  // R4
    {1'b1, 10'd2,    NONE,     NONE,     9'h100}   // R7
  };

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset run_id", run_id, NONE);
    chk("R4 reset run_prio", run_prio, 9'h100);
    chk("R10 reset ready", ack_ready, 1);
    chk("R1 reset rsp", ack_rsp_valid, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][39] == 1'b0) begin
        do_ack(VEC[v][38:29]);
        chk($sformatf("R1 vec%0d rsp", v), cap_rsp, 1);
        chk($sformatf("R1 vec%0d ack_id", v), cap_ack, VEC[v][28:19]);
        chk($sformatf("R3 vec%0d pclr", v), cap_pclr, VEC[v][28:19] != NONE);
      end else begin
        do_eoi(VEC[v][38:29]);
      end
      chk($sformatf("R7 vec%0d run_id", v), run_id, VEC[v][18:9]);
      chk($sformatf("R4 vec%0d run_prio", v), run_prio, VEC[v][8:0]);
    end

    // R3: clear scope depends on the one-of-N bit (set for source 1 only)
    do_ack(10'd4);
    chk("R3 pclr_id", cap_pclr_id, 10'd4);
    chk("R3 pclr_all per-cpu", cap_pall, 0);
    do_ack(10'd1);
    chk("R3 pclr_all all-cpu", cap_pall, 1);
    do_eoi(10'd1);
    chk("R7 back to 4", run_id, 10'd4);

    // R6: level source still asserted, enabled and targeted is set pending again
    src_level[4] = 1'b1; src_en[4] = 1'b1; src_tgt[4] = 1'b1;
    do_eoi(10'd4);
    chk("R6 pset_valid", cap_pset, 1);
    chk("R6 pset_id", cap_pset_id, 10'd4);
    src_edge[6] = 1'b1; src_level[6] = 1'b1; src_en[6] = 1'b1; src_tgt[6] = 1'b1;
    do_ack(10'd6);
    do_eoi(10'd6);
    chk("R6 edge source no pset", cap_pset, 0);
    src_edge[4] = 1'b0; src_tgt[4] = 1'b0;
    do_ack(10'd4);
    do_eoi(10'd4);
    chk("R6 untargeted no pset", cap_pset, 0);

    // R10/R8: two-link walk removing the bottom of a three-deep chain
    do_ack(10'd5);
    do_ack(10'd3);
    do_ack(10'd1);
    do_eoi(10'd5);
    chk("R10 busy during walk", cap_busy, 1);
    chk("R8 run unchanged", run_id, 10'd1);
    do_eoi(10'd1);
    chk("R7 run 3", run_id, 10'd3);
    do_eoi(10'd3);
    chk("R8 bottom removed", run_id, NONE);
    chk("R4 idle prio", run_prio, 9'h100);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule